// File: doc/BRIEF.md
# Endpoint FIFO Segment Allocator

This block hands out pieces of a shared endpoint FIFO memory. The memory is cut into fixed segments of `SEG_BYTES` bytes, 512 by default, and an occupancy map of `MAP_BITS` bits, 128 by default, records which segments are in use. With the defaults the map covers 64 KB.

An allocation request carries an endpoint's maximum packet size and a slot count. The block rounds the packet size up to a power of two. It multiplies that by one more than the slot count and works out how many segments the result spans. It then walks the map one bit per cycle, looking for the first run of free segments that is long enough. When it finds one, it marks the run as used and reports a byte address and a byte size. A release request gives back an address and a size and clears those segments in a single cycle.

Transmit and receive memories each get their own instance. Each instance is given its own base address and its own limit on how many map bits may be used.

Top module: `ep_fifo_seg_alloc`

## Requirements
- R1: The segment size equals `alloc_maxp` rounded up to the next power of two, with a packet size of 0 treated as 1. The reported `res_size` equals `(alloc_slot + 1)` times that segment size.
- R2: An allocation reserves ceil(`res_size` / 512) segments. The reported `res_addr` equals `cfg_base + first_segment_index * 512`, taken modulo 2^`ADDR_W`.
- R3: The chosen run is the one with the lowest starting index among all runs of free segments that lie entirely below the effective limit.
- R4: When no such run exists, `fail` is high in the same cycle as `done`, and the occupancy map is left unchanged.
- R5: A release, taken only while idle, clears the segments from index (`free_addr - cfg_base`) / 512 onward, ceil(`free_size` / 512) of them. The release takes one clock cycle, and no other segment is touched.
- R6: `busy` is high from the cycle after an allocation is accepted until `done` pulses high for exactly one cycle. A success takes `start + segments` search cycles. A failure takes `limit + 1` search cycles.
- R7: While `busy` is high, both `alloc_req` and `free_req` are ignored.
- R8: If `alloc_req` and `free_req` arrive together while idle, the release is applied and the allocation is dropped.
- R9: After reset the occupancy map is empty and `busy`, `done` and `fail` are low.
- R10: A `cfg_limit` larger than `MAP_BITS` behaves as `MAP_BITS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Byte address of segment 0 |
| cfg_limit | input | $clog2(MAP_BITS)+1 | Number of usable map bits |
| alloc_req | input | 1 | Start an allocation (accepted when idle) |
| alloc_maxp | input | MAXP_W | Maximum packet size in bytes |
| alloc_slot | input | SLOT_W | Extra buffers beyond the first |
| free_req | input | 1 | Release a run (accepted when idle) |
| free_addr | input | ADDR_W | Byte address of the run to release |
| free_size | input | MAXP_W+SLOT_W+1 | Byte size of the run to release |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| fail | output | 1 | Valid with done: no run fitted |
| res_addr | output | ADDR_W | Byte address of the granted run |
| res_size | output | MAXP_W+SLOT_W+1 | Byte size of the granted run |

## Verification
The bench targets packet sizes that sit just above and just below a power of two, and a packet size of zero. A faulty rounding circuit would report the wrong `res_size` in those cases, or reserve one segment too few. The bench also leaves a free hole that is too small to use below a larger free hole. A search that fails to reset its run counter when it meets a used bit would then place the grant across a used segment. Further cases cover a request that is larger than the limit, a limit set above the map width, and requests raised while a search is running or together with a release. In each of these, a design that got it wrong would shift where later grants land, or would change how many cycles the search takes.

// File: rtl/ep_fifo_alloc_pkg.sv
package ep_fifo_alloc_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SCAN = 1'b1
   } scan_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/fifo_seg_sizer.sv
module fifo_seg_sizer #(
   parameter int MAXP_W = 11,
   parameter int SLOT_W = 2,
   parameter int SEG_SH = 9,
   parameter int CNT_W  = 8
) (
   input  logic [MAXP_W-1:0]      maxp,
   input  logic [SLOT_W-1:0]      slot,
   output logic [MAXP_W:0]        seg_bytes,
   output logic [MAXP_W+SLOT_W:0] total_bytes,
   output logic [CNT_W-1:0]       seg_count
);
   localparam int SIZE_W = MAXP_W + SLOT_W + 1;

   logic [MAXP_W-1:0] below;
   logic [SIZE_W:0]   product;
   logic [SIZE_W:0]   rounded;

   // Round up to a power of two: the highest set bit of (maxp-1) picks it.
   always_comb begin
      below     = (maxp == '0) ? '0 : maxp - MAXP_W'(1);
      seg_bytes = (MAXP_W+1)'(1);
      for (int i = 0; i < MAXP_W; i++) begin
         if (below[i]) seg_bytes = (MAXP_W+1)'(1) << (i + 1);
      end
   end

   always_comb begin
      product     = (SIZE_W+1)'(seg_bytes) *
                    (SIZE_W+1)'((SLOT_W+1)'(slot) + (SLOT_W+1)'(1));
      total_bytes = product[SIZE_W-1:0];
      rounded     = (SIZE_W+1)'(total_bytes) + (SIZE_W+1)'((1 << SEG_SH) - 1);
      seg_count   = CNT_W'(rounded >> SEG_SH);
   end

endmodule

// File: rtl/seg_run_mask.sv
module seg_run_mask #(
   parameter int MAP_BITS = 128,
   parameter int IDX_W    = 7,
   parameter int CNT_W    = 8
) (
   input  logic [IDX_W-1:0]    start,
   input  logic [CNT_W-1:0]    len,
   output logic [MAP_BITS-1:0] mask
);
   logic [CNT_W:0] lo;
   logic [CNT_W:0] hi;

   assign lo = (CNT_W+1)'(start);
   assign hi = lo + (CNT_W+1)'(len);

   for (genvar b = 0; b < MAP_BITS; b++) begin : g_bit
      localparam logic [CNT_W:0] POS = (CNT_W+1)'(b);
      assign mask[b] = (POS >= lo) && (POS < hi);
   end

endmodule

// File: rtl/ep_fifo_seg_alloc.sv
module ep_fifo_seg_alloc
   import ep_fifo_alloc_pkg::*;
#(
   parameter int SEG_BYTES = 512,
   parameter int MAP_BITS  = 128,
   parameter int ADDR_W    = 16,
   parameter int MAXP_W    = 11,
   parameter int SLOT_W    = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             cfg_base,
   input  logic [$clog2(MAP_BITS):0]     cfg_limit,
   input  logic                          alloc_req,
   input  logic [MAXP_W-1:0]             alloc_maxp,
   input  logic [SLOT_W-1:0]             alloc_slot,
   input  logic                          free_req,
   input  logic [ADDR_W-1:0]             free_addr,
   input  logic [MAXP_W+SLOT_W:0]        free_size,
   output logic                          busy,
   output logic                          done,
   output logic                          fail,
   output logic [ADDR_W-1:0]             res_addr,
   output logic [MAXP_W+SLOT_W:0]        res_size
);
   localparam int SEG_SH  = $clog2(SEG_BYTES);
   localparam int IDX_W   = $clog2(MAP_BITS);
   localparam int CNT_W   = IDX_W + 1;
   localparam int SIZE_W  = MAXP_W + SLOT_W + 1;
   localparam int MAX_SEG = ((1 << MAXP_W) << SLOT_W) / SEG_BYTES;

   // elaboration-time parameter checks
   if (!is_pow2(SEG_BYTES)) begin : g_bad_seg
      $error("SEG_BYTES must be a power of two");
   end
   if (!is_pow2(MAP_BITS)) begin : g_bad_map
      $error("MAP_BITS must be a power of two");
   end
   if (ADDR_W < IDX_W + SEG_SH) begin : g_bad_addr
      $error("ADDR_W too narrow to span the map");
   end
   if (MAX_SEG > MAP_BITS) begin : g_bad_span
      $error("largest request exceeds the map");
   end

   scan_state_e           state_q;
   logic [MAP_BITS-1:0]   seg_map_q;
   logic [CNT_W-1:0]      idx_q;
   logic [IDX_W-1:0]      run_st_q;
   logic [CNT_W-1:0]      run_len_q;
   logic [CNT_W-1:0]      need_q;
   logic [SIZE_W-1:0]     size_q;

   logic [MAXP_W:0]       seg_bytes;
   logic [SIZE_W-1:0]     total_bytes;
   logic [CNT_W-1:0]      need_c;

   logic [CNT_W-1:0]      eff_limit;
   logic                  idle, alloc_go, free_go;
   logic                  at_end, cur_used, hit;
   logic [IDX_W-1:0]      run_st;
   logic [CNT_W-1:0]      run_len_nx;
   logic [MAP_BITS-1:0]   alloc_mask, free_mask;
   logic [ADDR_W-1:0]     free_off;
   logic [IDX_W-1:0]      free_start;
   logic [SIZE_W:0]       free_round;
   logic [CNT_W-1:0]      free_cnt;
   logic [ADDR_W-1:0]     grant_addr;

   fifo_seg_sizer #(
      .MAXP_W (MAXP_W),
      .SLOT_W (SLOT_W),
      .SEG_SH (SEG_SH),
      .CNT_W  (CNT_W)
   ) u_sizer (
      .maxp        (alloc_maxp),
      .slot        (alloc_slot),
      .seg_bytes   (seg_bytes),
      .total_bytes (total_bytes),
      .seg_count   (need_c)
   );

   // limit clamp (R10)
   assign eff_limit = (cfg_limit > CNT_W'(MAP_BITS)) ? CNT_W'(MAP_BITS) : cfg_limit;

   assign idle     = (state_q == ST_IDLE);
   assign busy     = (state_q == ST_SCAN);
   assign free_go  = idle && free_req;
   assign alloc_go = idle && alloc_req && !free_req;

   // search step
   assign at_end     = (idx_q >= eff_limit);
   assign cur_used   = seg_map_q[idx_q[IDX_W-1:0]];
   assign run_st     = (run_len_q == '0) ? idx_q[IDX_W-1:0] : run_st_q;
   assign run_len_nx = run_len_q + CNT_W'(1);
   assign hit        = busy && !at_end && !cur_used && (run_len_nx == need_q);
   assign grant_addr = cfg_base + (ADDR_W'(run_st) << SEG_SH);

   // release decode
   assign free_off   = free_addr - cfg_base;
   assign free_start = IDX_W'(free_off >> SEG_SH);
   assign free_round = (SIZE_W+1)'(free_size) + (SIZE_W+1)'(SEG_BYTES - 1);
   assign free_cnt   = CNT_W'(free_round >> SEG_SH);

   seg_run_mask #(
      .MAP_BITS (MAP_BITS),
      .IDX_W    (IDX_W),
      .CNT_W    (CNT_W)
   ) u_alloc_mask (
      .start (run_st),
      .len   (need_q),
      .mask  (alloc_mask)
   );

   seg_run_mask #(
      .MAP_BITS (MAP_BITS),
      .IDX_W    (IDX_W),
      .CNT_W    (CNT_W)
   ) u_free_mask (
      .start (free_start),
      .len   (free_cnt),
      .mask  (free_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         seg_map_q <= '0;
         idx_q     <= '0;
         run_st_q  <= '0;
         run_len_q <= '0;
         need_q    <= '0;
         size_q    <= '0;
         done      <= 1'b0;
         fail      <= 1'b0;
         res_addr  <= '0;
         res_size  <= '0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (free_go) begin
                  seg_map_q <= seg_map_q & ~free_mask;
               end else if (alloc_go) begin
                  state_q   <= ST_SCAN;
                  idx_q     <= '0;
                  run_len_q <= '0;
                  need_q    <= need_c;
                  size_q    <= total_bytes;
               end
            end
            ST_SCAN: begin
               idx_q <= idx_q + CNT_W'(1);
               if (at_end) begin
                  state_q <= ST_IDLE;
                  done    <= 1'b1;
                  fail    <= 1'b1;
               end else if (cur_used) begin
                  run_len_q <= '0;
               end else if (hit) begin
                  state_q   <= ST_IDLE;
                  seg_map_q <= seg_map_q | alloc_mask;
                  res_addr  <= grant_addr;
                  res_size  <= size_q;
                  done      <= 1'b1;
               end else begin
                  run_st_q  <= run_st;
                  run_len_q <= run_len_nx;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   logic [ADDR_W:0] grant_end;
   assign grant_end = (ADDR_W+1)'((res_addr - cfg_base) >> SEG_SH) + (ADDR_W+1)'(need_q);

   a_r1_seg_pow2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_go |-> ($countones(seg_bytes) == 1));

   a_r2_run_marked: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fail) |-> ((seg_map_q & $past(alloc_mask)) == $past(alloc_mask)));

   a_r3_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fail) |-> (grant_end <= (ADDR_W+1)'(eff_limit)));

   a_r4_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> done);

   a_r4_fail_map_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fail) |-> (seg_map_q == $past(seg_map_q)));

   a_r5_free_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $past(free_go) |-> ((seg_map_q & $past(free_mask)) == '0));

   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r7_need_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(need_q));

endmodule

// File: tb/ep_fifo_seg_alloc_test.sv
module ep_fifo_seg_alloc_test;
   localparam int ADDR_W = 16;
   localparam int MAXP_W = 11;
   localparam int SLOT_W = 2;
   localparam int SIZE_W = MAXP_W + SLOT_W + 1;
   localparam int NBITS  = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [ADDR_W-1:0] cfg_base = '0;
   logic [7:0]        cfg_limit = 8'd128;
   logic              alloc_req = 1'b0;
   logic [MAXP_W-1:0] alloc_maxp = '0;
   logic [SLOT_W-1:0] alloc_slot = '0;
   logic              free_req = 1'b0;
   logic [ADDR_W-1:0] free_addr = '0;
   logic [SIZE_W-1:0] free_size = '0;
   logic busy, done, fail;
   logic [ADDR_W-1:0] res_addr;
   logic [SIZE_W-1:0] res_size;

   int checks = 0;
   int failures = 0;
   bit mdl [NBITS];
   int rec_addr [64];
   int rec_size [64];
   int rec_n = 0;

   always #5 clk = ~clk;

   ep_fifo_seg_alloc uut (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
      .alloc_req(alloc_req), .alloc_maxp(alloc_maxp), .alloc_slot(alloc_slot),
      .free_req(free_req), .free_addr(free_addr), .free_size(free_size),
      .busy(busy), .done(done), .fail(fail), .res_addr(res_addr), .res_size(res_size)
   );

   task automatic chk(input string rq, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   function automatic int f_seg(input int maxp);
      int p = 1;
      while (p < maxp) p = p * 2;
      return p;
   endfunction

   function automatic int f_lim();
      return (cfg_limit > NBITS) ? NBITS : int'(cfg_limit);
   endfunction

   function automatic int f_fit(input int nd);
      for (int st = 0; st + nd <= f_lim(); st++) begin
         bit ok = 1'b1;
         for (int k = 0; k < nd; k++) if (mdl[st+k]) ok = 1'b0;
         if (ok) return st;
      end
      return -1;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NBITS; i++) mdl[i] = 1'b0;
      rec_n = 0;
      chk("R9 busy after reset", busy, 0);
      chk("R9 done after reset", done, 0);
      chk("R9 fail after reset", fail, 0);
   endtask

   // poke: raise alloc and free while the search runs (R7)
   task automatic do_alloc(input int maxp, input int slot, input bit poke, output int got);
      int seg, tot, nd, s, cyc, bad_busy;
      seg = f_seg(maxp);
      tot = seg * (slot + 1);
      nd  = (tot + 511) / 512;
      s   = f_fit(nd);
      @(negedge clk);
      alloc_maxp = MAXP_W'(maxp);
      alloc_slot = SLOT_W'(slot);
      alloc_req  = 1'b1;
      @(negedge clk);
      alloc_req  = 1'b0;
      cyc = 0;
      bad_busy = 0;
      while (1) begin
         @(negedge clk);
         free_req  = 1'b0;
         alloc_req = 1'b0;
         cyc++;
         if (done || cyc > 300) break;
         if (!busy) bad_busy++;
         if (poke && cyc == 1) begin
            alloc_maxp = 11'd1;
            alloc_slot = 2'd0;
            alloc_req  = 1'b1;
            free_req   = 1'b1;
            free_addr  = cfg_base;
            free_size  = SIZE_W'(8192);
         end
      end
      chk("R6 busy held during search", bad_busy, 0);
      chk("R6 busy low at done", busy, 0);
      if (s >= 0) begin
         chk("R4 no fail on fit", fail, 0);
         chk("R2 address", res_addr, (int'(cfg_base) + s * 512) % 65536);
         chk("R1 size", res_size, tot);
         chk("R6 search cycles", cyc, s + nd);
         for (int k = 0; k < nd; k++) mdl[s+k] = 1'b1;
         if (rec_n < 64) begin
            rec_addr[rec_n] = int'(res_addr);
            rec_size[rec_n] = tot;
            rec_n++;
         end
      end else begin
         chk("R4 fail flag", fail, 1);
         chk("R6 fail cycles", cyc, f_lim() + 1);
      end
      got = s;
      @(negedge clk);
      chk("R6 done one cycle", done, 0);
   endtask

   task automatic do_free(input int addr, input int size, input bit with_alloc);
      int st, nd;
      @(negedge clk);
      free_addr = ADDR_W'(addr);
      free_size = SIZE_W'(size);
      free_req  = 1'b1;
      if (with_alloc) begin
         alloc_maxp = 11'd64;
         alloc_slot = 2'd0;
         alloc_req  = 1'b1;
      end
      @(negedge clk);
      free_req  = 1'b0;
      alloc_req = 1'b0;
      st = ((addr - int'(cfg_base)) & 16'hFFFF) / 512;
      nd = (size + 511) / 512;
      for (int k = 0; k < nd; k++) if (st + k < NBITS) mdl[st+k] = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int g, busy_seen, done_seen;
      void'($urandom(32'd2024));
      cfg_base = '0;
      cfg_limit = 8'd128;
      do_reset();

      // R1 R2 R3: directed sizes
      do_alloc(512, 2, 0, g);   chk("R3 first at 0", g, 0);
      do_alloc(513, 0, 0, g);   chk("R1 513 rounds to 1024", g, 3);
      do_alloc(0, 0, 0, g);     chk("R1 zero packet", g, 5);
      do_alloc(100, 1, 0, g);   chk("R1 100x2 one segment", g, 6);
      // R5: release first run, then first-fit into it and past a small hole
      do_free(0, 1536, 0);
      do_alloc(1024, 0, 0, g);  chk("R5 R3 reuse freed", g, 0);
      do_alloc(1024, 0, 1, g);  chk("R3 R7 skip small hole", g, 7);
      do_alloc(1, 0, 0, g);     chk("R5 hole single bit", g, 2);

      // R8: simultaneous release and allocation
      do_free(512 * 7, 1024, 1);
      busy_seen = 0;
      done_seen = 0;
      repeat (4) begin
         @(negedge clk);
         if (busy) busy_seen++;
         if (done) done_seen++;
      end
      chk("R8 alloc dropped busy", busy_seen, 0);
      chk("R8 alloc dropped done", done_seen, 0);
      do_alloc(1024, 0, 0, g);  chk("R8 free applied", g, 7);

      // R4: limit too small, then map unchanged after fail
      cfg_base = 16'h4000;
      cfg_limit = 8'd6;
      do_reset();
      do_alloc(1024, 3, 0, g);  chk("R4 oversized fails", g, -1);
      do_alloc(1024, 2, 0, g);  chk("R4 map kept after fail", g, 0);
      do_alloc(1, 0, 0, g);     chk("R4 full fails", g, -1);

      // R10: limit above map width clamps
      cfg_base = '0;
      cfg_limit = 8'd200;
      do_reset();
      for (int i = 0; i < 8; i++) begin
         do_alloc(2047, 3, 0, g);
         chk("R10 fill", g, i * 16);
      end
      do_alloc(1, 0, 0, g);     chk("R10 clamp fail", g, -1);

      // random mix
      cfg_limit = 8'd128;
      do_reset();
      for (int it = 0; it < 120; it++) begin
         if (rec_n > 0 && ($urandom % 3) == 0) begin
            int j = int'($urandom % rec_n);
            do_free(rec_addr[j], rec_size[j], 0);
            rec_addr[j] = rec_addr[rec_n-1];
            rec_size[j] = rec_size[rec_n-1];
            rec_n--;
         end else begin
            do_alloc(int'($urandom % 1100), int'($urandom % 4), ($urandom % 4) == 0, g);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule